// File: doc/BRIEF.md
# Lockable SMRAM Window Control Register

This block is one byte-wide register in the configuration space of a host bridge. Firmware uses it to find out whether a fixed memory window, set aside for system-management-mode code, can be sealed. The window is then sealed so that ordinary code can no longer reach it. Firmware first writes a query command to the register. If the platform builds the feature in, the register then reads back a capability code. A separate seal command closes the window and freezes the register. After that it ignores every write until the next platform reset.

The block has two ports. The configuration side takes a byte offset, a write strobe and write data, and returns read data for the offset presented. The memory side takes an access address and a flag that marks the access as coming from system-management mode. It answers with a combinational allow/deny decision. A parameter sets whether the feature is present. Other parameters set the window base and size, which by default is 128 KiB at 0x30000, covering 0x30000 to 0x4FFFF. Further parameters set the register offset (default 0x9C) and the address width.

Top module: `smram_window_ctl`

## Requirements
- R1: After reset the register reads 0x00, is unsealed, and every memory access is allowed.
- R2: With the feature present, writing 0xFF at offset 0x9C while unsealed makes the register read 0x01 from the next cycle on.
- R3: With the feature absent, the register always reads 0x00, a seal write (0x02) is ignored, and every memory access is allowed.
- R4: While unsealed, written values other than 0xFF and 0x02 leave the register value unchanged.
- R5: With the feature present, writing 0x02 at offset 0x9C while unsealed seals the register, from the reset state or after a query. From the next cycle on it reads 0x02, and accesses with the mode flag low to an address from 0x30000 to 0x4FFFF inclusive are denied.
- R6: Once sealed, the register ignores every write value and keeps reading 0x02.
- R7: Accesses with the mode flag high are always allowed, and accesses outside 0x30000 to 0x4FFFF are always allowed.
- R8: Writes presented at any offset other than 0x9C leave the register unchanged.
- R9: Asserting reset unseals the window and returns the register to 0x00, after which it accepts a new query or seal.
- R10: The allow output is judged on the register state held before a write in the same cycle. An access in the cycle of a seal write is still allowed, and it is denied from the next cycle.
- R11: Reads presented at any offset other than 0x9C return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low platform reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_offset | input | OFS_W | Configuration byte offset for read and write |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_offset |
| mem_addr | input | ADDR_W | Address of the memory access being judged |
| mem_smm | input | 1 | High when the access comes from system-management mode |
| mem_allow | output | 1 | High when the access may proceed |

## Verification
A seal write and a memory access to the window can fall in the same cycle. In that cycle the allow decision must still reflect the unsealed state, and the denial must appear only after the clock edge. The bench sets up this overlap by presenting the seal write and a non-SMM access to 0x30000 at the same falling edge. It samples the allow output shortly after that edge and expects 1. It samples again at the next falling edge, once the write has been taken, and expects 0. A second instance built without the feature receives the same stimulus and must stay at 1 throughout.

// File: rtl/smw_pkg.sv
// Package smw_pkg
// Shared state encoding and byte codes for the lockable SMRAM window register.
// Assumes an 8-bit register; the codes below are the only values firmware sees.
package smw_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SMW_IDLE   = 2'd0,
        SMW_OPEN   = 2'd1,
        SMW_SEALED = 2'd2
    } smw_state_e;

    localparam logic [DATA_W-1:0] CMD_QUERY  = 8'hFF;
    localparam logic [DATA_W-1:0] CMD_SEAL   = 8'h02;
    localparam logic [DATA_W-1:0] RD_IDLE    = 8'h00;
    localparam logic [DATA_W-1:0] RD_PRESENT = 8'h01;
    localparam logic [DATA_W-1:0] RD_SEALED  = 8'h02;
endpackage

// File: rtl/smw_cfg_decode.sv
// Module smw_cfg_decode
// Turns a configuration write into one-cycle query/seal strobes.
// Assumes at most one write per cycle; other data values raise no strobe.
module smw_cfg_decode
    import smw_pkg::*;
#(
    parameter int                 OFS_W   = 8,
    parameter logic [OFS_W-1:0]   REG_OFS = 8'h9C
) (
    input  logic               cfg_wr_en,
    input  logic [OFS_W-1:0]   cfg_offset,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic               do_query,
    output logic               do_seal
);
    logic hit;

    // Address match for this register's own offset
    always_comb hit = cfg_wr_en && (cfg_offset == REG_OFS);

    // Command recognition on a matching write
    always_comb begin
        do_query = hit && (cfg_wdata == CMD_QUERY);
        do_seal  = hit && (cfg_wdata == CMD_SEAL);
    end
endmodule

// File: rtl/smw_state.sv
// Module smw_state
// Holds the idle/open/sealed state and produces the byte the register reads.
// Assumes do_query and do_seal are never both high; sealed state is left only by reset.
module smw_state
    import smw_pkg::*;
#(
    parameter bit FEATURE_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_query,
    input  logic               do_seal,
    output logic [DATA_W-1:0]  reg_view,
    output logic               sealed
);
    smw_state_e state_q, state_d;

    // Next-state choice: commands act only with the feature and while unsealed
    always_comb begin
        state_d = state_q;
        if (FEATURE_EN && state_q != SMW_SEALED) begin
            if (do_seal)
                state_d = SMW_SEALED;
            else if (do_query)
                state_d = SMW_OPEN;
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SMW_IDLE;
        else
            state_q <= state_d;
    end

    // Read-back byte and seal flag derived from the held state
    always_comb begin
        unique case (state_q)
            SMW_OPEN:   reg_view = RD_PRESENT;
            SMW_SEALED: reg_view = RD_SEALED;
            default:    reg_view = RD_IDLE;
        endcase
        sealed = (state_q == SMW_SEALED);
    end
endmodule

// File: rtl/smw_window_check.sv
// Module smw_window_check
// Flags whether an address falls inside [WIN_BASE, WIN_BASE+WIN_SIZE).
// Assumes the window fits in 2**ADDR_W; compares one bit wider to avoid wrap.
module smw_window_check #(
    parameter int          ADDR_W   = 20,
    parameter int unsigned WIN_BASE = 32'h0003_0000,
    parameter int unsigned WIN_SIZE = 32'h0002_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win
);
    localparam int          EXT_W  = ADDR_W + 1;
    localparam logic [EXT_W-1:0] LO_EXT = EXT_W'(WIN_BASE);
    localparam logic [EXT_W-1:0] HI_EXT = EXT_W'(WIN_BASE + WIN_SIZE);

    logic [EXT_W-1:0] addr_ext;

    // Range compare on a zero-extended address
    always_comb begin
        addr_ext = {1'b0, addr};
        in_win   = (addr_ext >= LO_EXT) && (addr_ext < HI_EXT);
    end
endmodule

// File: rtl/smram_window_ctl.sv
// Module smram_window_ctl
// Lockable SMRAM window control register: query handshake, seal, and
// an allow/deny decision for memory accesses to the protected window.
// Assumes a single-cycle config write and a combinational access check;
// the check uses the state held before any write in the same cycle.
module smram_window_ctl
    import smw_pkg::*;
#(
    parameter bit                 FEATURE_EN = 1'b1,
    parameter int                 ADDR_W     = 20,
    parameter int unsigned        WIN_BASE   = 32'h0003_0000,
    parameter int unsigned        WIN_SIZE   = 32'h0002_0000,
    parameter int                 OFS_W      = 8,
    parameter logic [OFS_W-1:0]   REG_OFS    = 8'h9C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [OFS_W-1:0]   cfg_offset,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_smm,
    output logic               mem_allow
);
    logic              do_query;
    logic              do_seal;
    logic [DATA_W-1:0] reg_view;
    logic              sealed;
    logic              in_win;

    smw_cfg_decode #(
        .OFS_W   (OFS_W),
        .REG_OFS (REG_OFS)
    ) u_dec (
        .cfg_wr_en  (cfg_wr_en),
        .cfg_offset (cfg_offset),
        .cfg_wdata  (cfg_wdata),
        .do_query   (do_query),
        .do_seal    (do_seal)
    );

    smw_state #(
        .FEATURE_EN (FEATURE_EN)
    ) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_query (do_query),
        .do_seal  (do_seal),
        .reg_view (reg_view),
        .sealed   (sealed)
    );

    smw_window_check #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_win (
        .addr   (mem_addr),
        .in_win (in_win)
    );

    // Read mux: only this register's offset returns its value
    always_comb cfg_rdata = (cfg_offset == REG_OFS) ? reg_view : RD_IDLE;

    // Access decision: mode flag, unsealed state or out-of-window address allow
    always_comb mem_allow = mem_smm || !sealed || !in_win;
endmodule

// File: rtl/smw_checker.sv
// Module smw_checker
// Assertions for smram_window_ctl, attached by bind below.
module smw_checker
    import smw_pkg::*;
#(
    parameter bit                 FEATURE_EN = 1'b1,
    parameter int                 ADDR_W     = 20,
    parameter int unsigned        WIN_BASE   = 32'h0003_0000,
    parameter int unsigned        WIN_SIZE   = 32'h0002_0000,
    parameter int                 OFS_W      = 8,
    parameter logic [OFS_W-1:0]   REG_OFS    = 8'h9C
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr_en,
    input logic [OFS_W-1:0]   cfg_offset,
    input logic [7:0]         cfg_wdata,
    input logic [7:0]         cfg_rdata,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_smm,
    input logic               mem_allow,
    input logic [7:0]         reg_view
);
    logic in_range;
    always_comb in_range = ({1'b0, mem_addr} >= (ADDR_W+1)'(WIN_BASE)) &&
                           ({1'b0, mem_addr} <  (ADDR_W+1)'(WIN_BASE + WIN_SIZE));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> reg_view == RD_IDLE);

    // R2
    query_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (FEATURE_EN && cfg_wr_en && cfg_offset == REG_OFS && cfg_wdata == CMD_QUERY
         && reg_view != RD_SEALED) |=> reg_view == RD_PRESENT);

    // R3
    absent_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !FEATURE_EN |-> (reg_view == RD_IDLE && mem_allow));

    // R5
    sealed_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_view == RD_SEALED && !mem_smm && in_range) |-> !mem_allow);

    // R6
    seal_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_view == RD_SEALED |=> reg_view == RD_SEALED);

    // R7
    smm_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_smm || !in_range) |-> mem_allow);

    // R8
    other_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_offset != REG_OFS) |=> $stable(reg_view));

    // R11
    other_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_offset != REG_OFS |-> cfg_rdata == RD_IDLE);
endmodule

bind smram_window_ctl smw_checker #(
    .FEATURE_EN (FEATURE_EN),
    .ADDR_W     (ADDR_W),
    .WIN_BASE   (WIN_BASE),
    .WIN_SIZE   (WIN_SIZE),
    .OFS_W      (OFS_W),
    .REG_OFS    (REG_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_offset (cfg_offset),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .mem_addr   (mem_addr),
    .mem_smm    (mem_smm),
    .mem_allow  (mem_allow),
    .reg_view   (reg_view)
);

// File: tb/sim_smram_window_ctl.sv
`timescale 1ns/1ps
// Bench sim_smram_window_ctl
// Drives one feature-present instance (u0) and one feature-absent instance
// (u1) with the same stimulus and checks read-back and allow decisions.
module sim_smram_window_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  ofs = 8'h9C;
    logic [7:0]  wdata = 8'h00;
    logic [19:0] addr = '0;
    logic        smm = 1'b0;
    logic [7:0]  rdata0, rdata1;
    logic        allow0, allow1;
    int          checks = 0;
    int          errors = 0;
    bit          sealed0 = 1'b0;

    always #4 clk = ~clk;

    smram_window_ctl #(.FEATURE_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_offset(ofs),
        .cfg_wdata(wdata), .cfg_rdata(rdata0), .mem_addr(addr),
        .mem_smm(smm), .mem_allow(allow0));

    smram_window_ctl #(.FEATURE_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_offset(ofs),
        .cfg_wdata(wdata), .cfg_rdata(rdata1), .mem_addr(addr),
        .mem_smm(smm), .mem_allow(allow1));

    function automatic bit exp_allow(int a, bit s, bit sl);
        return s || !sl || !(a >= 'h30000 && a <= 'h4FFFF);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] o, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; ofs = o; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; ofs = 8'h9C;
    endtask

    task automatic rdchk(string req, int e0, int e1);
        ofs = 8'h9C;
        #1;
        chk(req, rdata0, e0);
        chk(req, rdata1, e1);
    endtask

    task automatic memchk(string req, int a, bit s);
        addr = a[19:0]; smm = s;
        #1;
        chk(req, allow0, exp_allow(a, s, sealed0));
        chk(req, allow1, 1);
    endtask

    task automatic sweep(string req);
        for (int a = 0; a < (1 << 20); a += 'h800) begin
            memchk(req, a, 1'b0);
            memchk(req, a, 1'b1);
        end
        memchk(req, 'h2FFFF, 1'b0);
        memchk(req, 'h30000, 1'b0);
        memchk(req, 'h4FFFF, 1'b0);
        memchk(req, 'h50000, 1'b0);
        memchk(req, 'h4FFFF, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        sealed0 = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rdchk("R1", 0, 0);
        memchk("R1", 'h30000, 1'b0);

        // R4: non-command values ignored while idle
        for (int v = 0; v < 256; v++) begin
            if (v != 'hFF && v != 'h02) begin
                wr(8'h9C, 8'(v));
                rdchk("R4", 0, 0);
            end
        end

        // R8: commands at other offsets ignored
        for (int o = 0; o < 256; o++) begin
            if (o != 'h9C) begin
                wr(8'(o), 8'hFF);
                wr(8'(o), 8'h02);
                rdchk("R8", 0, 0);
            end
        end

        // R2 / R3: query
        wr(8'h9C, 8'hFF);
        rdchk("R2", 1, 0);

        // R11: other offsets read zero
        for (int o = 0; o < 256; o++) begin
            if (o != 'h9C) begin
                ofs = 8'(o);
                #1;
                chk("R11", rdata0, 0);
            end
        end
        ofs = 8'h9C;

        // R4: non-command values ignored while open
        wr(8'h9C, 8'h00); rdchk("R4", 1, 0);
        wr(8'h9C, 8'h01); rdchk("R4", 1, 0);
        wr(8'h9C, 8'h03); rdchk("R4", 1, 0);
        wr(8'h9C, 8'hFE); rdchk("R4", 1, 0);

        // R7 / R1: open window allows all
        sweep("R7");

        // R10: seal write and window access in the same cycle
        @(negedge clk);
        wr_en = 1'b1; ofs = 8'h9C; wdata = 8'h02;
        addr = 20'h30000; smm = 1'b0;
        #1;
        chk("R10", allow0, 1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R10", allow0, 0);
        chk("R3", allow1, 1);
        sealed0 = 1'b1;
        rdchk("R5", 2, 0);

        // R5 / R7: sealed window sweep
        sweep("R5");

        // R6: every write ignored once sealed
        for (int v = 0; v < 256; v++) begin
            wr(8'h9C, 8'(v));
            rdchk("R6", 2, 0);
        end
        memchk("R6", 'h40000, 1'b0);

        // R9: reset reopens, then seal directly from idle
        do_reset();
        rdchk("R9", 0, 0);
        memchk("R9", 'h30000, 1'b0);
        wr(8'h9C, 8'h02);
        sealed0 = 1'b1;
        rdchk("R5", 2, 0);
        memchk("R5", 'h3ABCD, 1'b0);
        memchk("R7", 'h3ABCD, 1'b1);
        do_reset();
        rdchk("R9", 0, 0);
        wr(8'h9C, 8'hFF);
        rdchk("R9", 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule